// File: doc/BRIEF.md
# Legacy OLED Command Translator

This block sits on the 8-bit parallel write path between a host and a display controller. The host's firmware expects an older controller with 132 columns of memory, of which only columns 2 to 129 are visible. The attached controller has exactly 128 columns, all of them visible. The block watches every command and data write and keeps its own copy of the host's column pointer and page. It then regenerates the write stream so the new panel shows the same image.

Four rewrites are applied. Column-address commands are translated into the 128-column window and re-emitted as a lower/upper nibble pair. Data bytes that fall outside the visible window are dropped, and the host's pointer still advances past them. The segment-direction command is swapped so the picture is not mirrored. The first burst of data written to the bottom page is forced to zero. That burst is the host writing back bytes it read from a controller that cannot be read, so it would otherwise fill the rows with 0xFF.

The design runs on a single clock that samples one-cycle host write strobes. Host writes are spaced at least two cycles apart, which leaves room for the extra nibble beat.

Top module: `disp_cmd_xlate`

## Requirements
- R1: After reset the output strobe is low, the tracked column is 0, the tracked page is 0 and the zeroing window is unused. A data byte written straight after reset is therefore dropped.
- R2: A host strobe is a single-cycle pulse, and two strobes are at least two cycles apart. Each forwarded byte appears on the output with its strobe exactly one cycle after the host strobe.
- R3: Command 0x00–0x0F sets tracked column bits 3:0, and command 0x10–0x1F sets bits 7:4. Each of these commands produces two output commands. The first, one cycle after the host strobe, is 0x00 | T[3:0]. The second, in the following cycle, is 0x10 | T[7:4]. T is the tracked column minus 2 when the column is in 2..129, and 0 otherwise.
- R4: A data byte whose tracked column is below 2 or above 129 produces no output beat. Every data byte, forwarded or dropped, advances the tracked column by one. A column of 131 or more wraps to 0.
- R5: Command 0xA0 is forwarded as 0xA1, and 0xA1 is forwarded as 0xA0.
- R6: Commands 0xB0–0xB7 are forwarded unchanged and set the tracked page to their low three bits.
- R7: The byte following any of 0x81, 0x82, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA or 0xDB is an argument. It is forwarded unchanged and is never decoded as a column, page or segment command.
- R8: The first data byte written while the tracked page is 7 opens the zeroing window. It closes at the next column or page command. It opens only once after reset. Forwarded data inside the window is 0x00.
- R9: All other commands, and data outside the zeroing window, are forwarded unchanged with the data/command flag preserved (1 = data).
- R10: For a host that draws every legacy column of every page, the new panel's column c on page p ends up holding the host's byte for legacy column c+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| host_stb | input | 1 | Single-cycle host write strobe |
| host_dc | input | 1 | Host data (1) or command (0) flag |
| host_d | input | 8 | Host write byte |
| disp_stb | output | 1 | Single-cycle write strobe toward the panel |
| disp_dc | output | 1 | Data (1) or command (0) flag toward the panel |
| disp_d | output | 8 | Byte toward the panel |

## Verification
The hardest situation to reach is a burst that crosses the pointer wrap while hidden columns sit on both sides of the visible window. In that case bytes at 128 and 129 land at panel columns 126 and 127, the next four bytes vanish, and the stream resumes at panel column 0. The bench reaches it by placing the host column at 128 with a nibble pair and writing eight bytes. It reaches the one-shot write-back case by starting a page-7 burst at an out-of-range column, which wraps before any visible byte is written. The result is compared against a 128x64 panel model that is rebuilt from the output strobes.

// File: rtl/disp_cmd_xlate.sv
module disp_cmd_xlate #(
  parameter int LEG_COLS = 132,
  parameter int VIS_COLS = 128,
  parameter int COL_OFS  = 2,
  parameter int PAGES    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_stb,
  input  logic       host_dc,
  input  logic [7:0] host_d,
  output logic       disp_stb,
  output logic       disp_dc,
  output logic [7:0] disp_d
);
  localparam int PW = $clog2(PAGES);
  localparam logic [7:0] C_LO   = 8'(COL_OFS);
  localparam logic [7:0] C_HI   = 8'(COL_OFS + VIS_COLS - 1);
  localparam logic [7:0] C_WRAP = 8'(LEG_COLS - 1);
  localparam logic [PW-1:0] LAST_PG = PW'(PAGES - 1);
  localparam logic [1:0] Z_IDLE = 2'd0, Z_ACT = 2'd1, Z_DONE = 2'd2;

  logic [7:0]    col_q;
  logic [PW-1:0] page_q;
  logic          arg_q;
  logic [1:0]    zst_q;
  logic          hi_pend_q;
  logic [3:0]    hi_nib_q;

  wire is_cmd = host_stb && !host_dc;
  wire is_dat = host_stb && host_dc;
  wire plain  = is_cmd && !arg_q;
  wire col_lo = plain && host_d[7:4] == 4'h0;
  wire col_hi = plain && host_d[7:4] == 4'h1;
  wire pg_cmd = plain && host_d[7:4] == 4'hB && host_d[3:0] < 4'(PAGES);
  wire seg    = plain && host_d[7:1] == 7'h50;
  wire argcmd = plain && (host_d inside {8'h81, 8'h82, 8'hA8, 8'hAD, 8'hD3,
                                          8'hD5, 8'hD8, 8'hD9, 8'hDA, 8'hDB});

  wire [7:0] col_new = col_lo ? {col_q[7:4], host_d[3:0]} : {host_d[3:0], col_q[3:0]};
  wire       new_vis = col_new >= C_LO && col_new <= C_HI;
  wire       cur_vis = col_q >= C_LO && col_q <= C_HI;
  wire [7:0] tcol    = new_vis ? col_new - C_LO : 8'h00;
  wire       zero_on = zst_q == Z_ACT || (zst_q == Z_IDLE && page_q == LAST_PG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      page_q    <= '0;
      arg_q     <= 1'b0;
      zst_q     <= Z_IDLE;
      hi_pend_q <= 1'b0;
      hi_nib_q  <= '0;
      disp_stb  <= 1'b0;
      disp_dc   <= 1'b0;
      disp_d    <= '0;
    end else begin
      disp_stb  <= 1'b0;
      hi_pend_q <= 1'b0;
      if (hi_pend_q) begin
        disp_stb <= 1'b1;
        disp_dc  <= 1'b0;
        disp_d   <= {4'h1, hi_nib_q};
      end
      if (is_dat) begin
        disp_stb <= cur_vis;
        disp_dc  <= 1'b1;
        disp_d   <= zero_on ? 8'h00 : host_d;
        col_q    <= (col_q >= C_WRAP) ? 8'h00 : col_q + 8'h01;
        if (zero_on) zst_q <= Z_ACT;
      end else if (is_cmd) begin
        disp_stb <= 1'b1;
        disp_dc  <= 1'b0;
        arg_q    <= argcmd;
        if (col_lo || col_hi) begin
          col_q     <= col_new;
          disp_d    <= {4'h0, tcol[3:0]};
          hi_pend_q <= 1'b1;
          hi_nib_q  <= tcol[7:4];
          if (zst_q == Z_ACT) zst_q <= Z_DONE;
        end else if (pg_cmd) begin
          page_q <= host_d[PW-1:0];
          disp_d <= host_d;
          if (zst_q == Z_ACT) zst_q <= Z_DONE;
        end else if (seg) begin
          disp_d <= {host_d[7:1], ~host_d[0]};
        end else begin
          disp_d <= host_d;
        end
      end
    end
  end
endmodule

// File: rtl/disp_cmd_xlate_chk.sv
module disp_cmd_xlate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_stb,
  input logic       host_dc,
  input logic [7:0] host_d,
  input logic       disp_stb,
  input logic       disp_dc,
  input logic [7:0] disp_d,
  input logic [7:0] col_q,
  input logic       arg_q,
  input logic [1:0] zst_q
);
  p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_stb |=> !host_stb);

  p_hi_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stb && !$past(host_stb) |-> !disp_dc && disp_d[7:4] == 4'h1);

  p_lo_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_stb && !host_dc && !arg_q && host_d[7:4] == 4'h0
      |=> disp_stb && !disp_dc && disp_d[7:4] == 4'h0 ##1 disp_stb && disp_d[7:4] == 4'h1);

  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_stb && host_dc && (col_q < 8'd2 || col_q > 8'd129) |=> !disp_stb);

  p_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_stb && !host_dc && !arg_q && host_d == 8'hA1 |=> disp_stb && disp_d == 8'hA0);

  p_arg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_stb && !host_dc && arg_q |=> disp_stb && !disp_dc && disp_d == $past(host_d));

  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_stb && host_dc && zst_q == 2'd1 |=> !disp_stb || disp_d == 8'h00);

  p_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_stb && host_dc && zst_q == 2'd2 && col_q >= 8'd2 && col_q <= 8'd129
      |=> disp_stb && disp_dc && disp_d == $past(host_d));
endmodule

bind disp_cmd_xlate disp_cmd_xlate_chk i_chk (.*);

// File: tb/test_disp_cmd_xlate.sv
module test_disp_cmd_xlate;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_stb = 1'b0, host_dc = 1'b0;
  logic [7:0] host_d = 8'h00;
  logic disp_stb, disp_dc;
  logic [7:0] disp_d;

  int checks = 0, failures = 0;
  logic [7:0] dfb [8][128];
  logic [7:0] lfb [8][132];
  int dpage = 0, dcol = 0, nout = 0, ndat = 0;
  logic [7:0] last_out = 8'h00;
  int lcol = 0, lpage = 0;

  always #(CLK_NS/2) clk = ~clk;

  disp_cmd_xlate i_disp_cmd_xlate (.*);

  always @(negedge clk) begin
    if (disp_stb) begin
      nout++;
      last_out = disp_d;
      if (disp_dc) begin
        ndat++;
        dfb[dpage][dcol] = disp_d;
        dcol = (dcol + 1) % 128;
      end else if (disp_d[7:4] == 4'h0) dcol = (dcol & 8'h70) | int'(disp_d[3:0]);
      else if (disp_d[7:4] == 4'h1) dcol = (dcol & 8'h0F) | (int'(disp_d[2:0]) << 4);
      else if (disp_d[7:3] == 5'b10110) dpage = int'(disp_d[2:0]);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_wr(input bit dc, input logic [7:0] d);
    @(negedge clk);
    host_stb = 1'b1; host_dc = dc; host_d = d;
    @(negedge clk);
    host_stb = 1'b0;
    @(negedge clk);
    #1;
  endtask

  task automatic host_cmd(input logic [7:0] d);
    if (d[7:4] == 4'h0) lcol = (lcol & 8'hF0) | int'(d[3:0]);
    if (d[7:4] == 4'h1) lcol = (lcol & 8'h0F) | (int'(d[3:0]) << 4);
    if (d[7:3] == 5'b10110) lpage = int'(d[2:0]);
    host_wr(1'b0, d);
  endtask

  task automatic host_dat(input logic [7:0] d, input bit z);
    if (lcol < 132) lfb[lpage][lcol] = z ? 8'h00 : d;
    lcol = (lcol >= 131) ? 0 : lcol + 1;
    host_wr(1'b1, d);
  endtask

  function automatic logic [7:0] pat(input int p, input int c);
    return 8'(((p * 29 + c * 7) % 255) + 1);
  endfunction

  initial begin
    #(CLK_NS * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n0, bad;
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 128; c++) dfb[p][c] = 8'hAA;
      for (int c = 0; c < 132; c++) lfb[p][c] = 8'hAA;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(disp_stb == 1'b0, "R1 idle strobe", int'(disp_stb), 0);

    host_dat(8'h55, 1'b0);
    chk(nout == 0, "R1 col0 drop after reset", nout, 0);

    host_cmd(8'hA1);
    chk(last_out == 8'hA0, "R5 A1 to A0", int'(last_out), 'hA0);
    host_cmd(8'hA0);
    chk(last_out == 8'hA1, "R5 A0 to A1", int'(last_out), 'hA1);

    n0 = nout;
    host_wr(1'b0, 8'h81);
    host_wr(1'b0, 8'h10);
    chk(nout - n0 == 2 && last_out == 8'h10, "R7 argument passthrough", nout - n0, 2);

    host_cmd(8'hE3);
    chk(last_out == 8'hE3, "R9 other command", int'(last_out), 'hE3);

    host_cmd(8'hB2);
    chk(last_out == 8'hB2 && dpage == 2, "R6 page passthrough", dpage, 2);

    host_cmd(8'h10);
    n0 = nout;
    host_cmd(8'h05);
    chk(nout - n0 == 2, "R2 two beats per column command", nout - n0, 2);
    chk(dcol == 3, "R3 column 5 to 3", dcol, 3);
    host_cmd(8'h00);
    host_cmd(8'h18);
    chk(dcol == 126, "R3 column 128 to 126", dcol, 126);

    host_cmd(8'hB7);
    host_cmd(8'h01);
    host_cmd(8'h1F);
    n0 = ndat;
    for (int i = 0; i < 131; i++) host_dat(8'hFF, 1'b1);
    chk(ndat - n0 == 128, "R4 writeback forwarded count", ndat - n0, 128);
    bad = 0;
    for (int c = 0; c < 128; c++) if (dfb[7][c] != 8'h00) bad++;
    chk(bad == 0, "R8 writeback zeroed", bad, 0);
    host_cmd(8'hB0);

    for (int p = 0; p < 8; p++) begin
      host_cmd(8'hB0 | 8'(p));
      host_cmd(8'h00);
      host_cmd(8'h10);
      for (int c = 0; c < 132; c++) host_dat(pat(p, c), 1'b0);
    end

    host_cmd(8'hB3);
    host_cmd(8'h00);
    host_cmd(8'h10);
    for (int i = 0; i < 6; i++) host_dat(8'h18, 1'b0);
    chk(dfb[3][0] == 8'h18 && dfb[3][3] == 8'h18, "R4 minus sign from hidden col",
        int'(dfb[3][0]), 'h18);

    host_cmd(8'hB5);
    host_cmd(8'h00);
    host_cmd(8'h18);
    n0 = ndat;
    for (int i = 0; i < 8; i++) host_dat(8'hC3 ^ 8'(i), 1'b0);
    chk(ndat - n0 == 4, "R4 wrap burst forwarded count", ndat - n0, 4);

    for (int p = 0; p < 8; p++) begin
      bad = 0;
      for (int c = 0; c < 128; c++) if (dfb[p][c] != lfb[p][c + 2]) bad++;
      chk(bad == 0, "R10 frame page compare", bad, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule